// File: doc/BRIEF.md
# SPI Flash Master with Register Interface

This block is a serial master that talks to one flash device. Software drives it through a small register window on a 32-bit bus. It stores the mode, the length and the enables in a command register. It queues outgoing words in a four-entry transmit queue and then raises a start bit. Each start shifts one word of 1 to 32 bits out on the data-out pin, most significant bit first. During the same transfer it collects the same number of bits from the data-in pin and pushes them, right-justified, into a four-entry receive queue.

A status register reports the busy state, a sticky completion flag, the queue levels and two sticky error flags. The error flags mark a write to a full transmit queue and a read from an empty receive queue. Software clears the sticky flags by writing ones to them, so writing back a value just read clears every pending event. Software can also empty either queue with a write-one flush bit.

Chip select is active low. Software can force it through an inverted control bit, which lets it hold the device selected across several transfers. The serial clock is the system clock divided by an even parameter.

Top module: `sfm_master`

## Requirements
- R1: Register byte offsets: command 0x00, status 0x04, transmit push 0x10, receive pop 0x20. The command register reads back the written value masked to its stored fields 0x0C0CF01F, and bit 30 always reads as 0.
- R2: Writing the command register with bit 30 set while the block is idle starts one transfer of (bits 4:0)+1 bits, so 7 gives 8 bits and 31 gives 32 bits. A start written while a transfer is running is ignored.
- R3: Command bit 26 sets the idle level of the serial clock (polarity). Command bit 18 selects the data edge: with 0, data is sampled on the leading clock edge and changed on the trailing edge; with 1, data is changed on the leading edge and sampled on the trailing edge. The serial clock period is DIV system clocks.
- R4: The transmit word is used right-justified: its low n bits go out most significant first, and the bits above them are ignored. The n received bits form the low n bits of the receive word in arrival order, with the upper bits at zero.
- R5: With command bit 12 set, the chip-select pin is the inverse of command bit 13. With bit 12 clear, the pin is low exactly while a transfer is busy.
- R6: On the clock where the last bit completes, BSY (status bit 31) clears, RDY (status bit 30) sets, and the received word is pushed into the receive queue if receive is enabled (command bit 14) and the queue is not full.
- R7: A transmit-port write while the transmit queue is full drops the data and sets the overflow flag, status bit 26.
- R8: A receive-port read while the receive queue is empty returns zero and sets the underrun flag, status bit 27.
- R9: Status bits 30, 27 and 26 are sticky and are cleared by writing 1 to them at the status offset. Other written status bits do not change them.
- R10: Each queue is 4 entries deep and first-in first-out. Status bit 25 means receive empty, bit 24 receive full, bit 23 transmit empty and bit 22 transmit full.
- R11: Writing 1 to status bit 29 empties the receive queue, and writing 1 to status bit 28 empties the transmit queue.
- R12: With transmit disabled (command bit 15 clear), a transfer shifts out zeros and leaves the transmit queue untouched. With receive disabled (command bit 14 clear), nothing is pushed into the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
On every clock, the assertions check the following. An accepted start raises busy. The serial clock phase is at rest whenever the engine is idle. Completion clears busy and sets RDY on the same edge. A write to a full transmit queue or a read from an empty receive queue raises its sticky flag, and a full queue holds its count against a push. Other behaviour needs a device on the far side of the pins, and only the bench scenarios can show it. This covers the bit order and right-justification for every length in all four clock modes, the serial clock period and idle level, queue ordering, flushes, and the ignored second start.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [5:0] OFS_CMD  = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_TXQ  = 6'h10;
  localparam logic [5:0] OFS_RXQ  = 6'h20;

  // command field positions
  localparam int unsigned C_START = 30;
  localparam int unsigned C_POL   = 26;
  localparam int unsigned C_EDGE  = 18;
  localparam int unsigned C_TXON  = 15;
  localparam int unsigned C_RXON  = 14;
  localparam int unsigned C_SELV  = 13;
  localparam int unsigned C_SELSW = 12;
  localparam logic [31:0] CMD_KEEP = 32'h0C0C_F01F;

  // status field positions
  localparam int unsigned S_BSY   = 31;
  localparam int unsigned S_RDY   = 30;
  localparam int unsigned S_RXFL  = 29;
  localparam int unsigned S_TXFL  = 28;
  localparam int unsigned S_UNR   = 27;
  localparam int unsigned S_OVF   = 26;

  // number of bits for a length field value
  function automatic logic [5:0] len_bits(input logic [4:0] lenm1);
    return {1'b0, lenm1} + 6'd1;
  endfunction

  // move the low n bits of a word to the top so bit 31 leaves first
  function automatic logic [31:0] to_msb(input logic [31:0] w, input logic [5:0] n);
    return w << (6'd32 - n);
  endfunction

  // last edge index of an n-bit transfer (two edges per bit)
  function automatic logic [6:0] last_edge(input logic [5:0] n);
    return {n, 1'b0} - 7'd1;
  endfunction
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  // R10: a full queue keeps its level when only a push arrives
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(cnt));
  // R10: level never passes the depth
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter
  import sfm_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  nbits,
  input  logic        pol,
  input  logic        edge_sel,
  input  logic        idle_pol,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [31:0] rx_word,
  output logic        sck,
  output logic        mosi
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = $clog2(HALF + 1);

  logic [CW-1:0] div_cnt;
  logic [6:0]    edge_cnt;
  logic [5:0]    n_q;
  logic          pol_q, edge_q, phase, mosi_q;
  logic [31:0]   sh, rx;
  logic          tick, leading, is_last, accept;
  logic [31:0]   first;

  assign accept  = start && !busy;
  assign tick    = busy && (div_cnt == CW'(HALF - 1));
  assign leading = !phase;
  assign is_last = (edge_cnt == last_edge(n_q));
  assign done    = tick && is_last;
  assign first   = to_msb(tx_word, nbits);
  // the final sample in late-edge mode lands on the completing edge
  assign rx_word = edge_q ? {rx[30:0], miso} : rx;
  assign sck     = busy ? (pol_q ^ phase) : idle_pol;
  assign mosi    = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      n_q      <= 6'd1;
      pol_q    <= 1'b0;
      edge_q   <= 1'b0;
      sh       <= '0;
      rx       <= '0;
      mosi_q   <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      n_q      <= nbits;
      pol_q    <= pol;
      edge_q   <= edge_sel;
      rx       <= '0;
      if (!edge_sel) begin
        mosi_q <= first[31];
        sh     <= first << 1;
      end else begin
        mosi_q <= 1'b0;
        sh     <= first;
      end
    end else if (busy) begin
      if (tick) begin
        div_cnt  <= '0;
        phase    <= ~phase;
        edge_cnt <= edge_cnt + 7'd1;
        if (leading == edge_q) begin
          // change edge
          if (edge_q || !is_last) begin
            mosi_q <= sh[31];
            sh     <= sh << 1;
          end
        end else begin
          rx <= {rx[30:0], miso};
        end
        if (is_last) busy <= 1'b0;
      end else begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  // R2: an accepted start makes the engine busy on the next clock
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R3: the clock phase rests whenever the engine is idle
  a_r3_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phase);
  // R6: completion ends the busy period
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/sfm_master.sv
module sfm_master
  import sfm_pkg::*;
#(
  parameter int unsigned DIV        = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [31:0] cmd_q, cmd_new, tx_head, rx_head, rx_word;
  logic        stat_rdy, stat_unr, stat_ovf;
  logic        busy, done;
  logic        cmd_hit, stat_hit, tx_hit, rx_hit, go;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic        tx_pop, rx_push, rx_pop, tx_flush, rx_flush;
  logic [31:0] tx_word;

  assign cmd_hit  = reg_wr_en && (reg_addr == OFS_CMD);
  assign stat_hit = reg_wr_en && (reg_addr == OFS_STAT);
  assign tx_hit   = reg_wr_en && (reg_addr == OFS_TXQ);
  assign rx_hit   = reg_rd_en && (reg_addr == OFS_RXQ);
  assign cmd_new  = reg_wdata & CMD_KEEP;
  assign go       = cmd_hit && reg_wdata[C_START];

  assign tx_pop   = go && !busy && cmd_new[C_TXON] && !tx_empty;
  assign tx_word  = (cmd_new[C_TXON] && !tx_empty) ? tx_head : '0;
  assign rx_push  = done && cmd_q[C_RXON];
  assign rx_pop   = rx_hit;
  assign tx_flush = stat_hit && reg_wdata[S_TXFL];
  assign rx_flush = stat_hit && reg_wdata[S_RXFL];

  sfm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_hit), .wdata(reg_wdata),
    .pop(tx_pop), .flush(tx_flush), .rdata(tx_head),
    .empty(tx_empty), .full(tx_full));

  sfm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .flush(rx_flush), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full));

  sfm_shifter #(.DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(go),
    .nbits(len_bits(cmd_new[4:0])), .pol(cmd_new[C_POL]),
    .edge_sel(cmd_new[C_EDGE]), .idle_pol(cmd_q[C_POL]),
    .tx_word(tx_word), .miso(spi_miso), .busy(busy), .done(done),
    .rx_word(rx_word), .sck(spi_sck), .mosi(spi_mosi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      stat_rdy <= 1'b0;
      stat_unr <= 1'b0;
      stat_ovf <= 1'b0;
    end else begin
      if (cmd_hit) cmd_q <= cmd_new;
      stat_rdy <= done | (stat_rdy & ~(stat_hit & reg_wdata[S_RDY]));
      stat_unr <= (rx_hit & rx_empty) | (stat_unr & ~(stat_hit & reg_wdata[S_UNR]));
      stat_ovf <= (tx_hit & tx_full) | (stat_ovf & ~(stat_hit & reg_wdata[S_OVF]));
    end
  end

  assign spi_cs_n = cmd_q[C_SELSW] ? ~cmd_q[C_SELV] : ~busy;

  always_comb begin
    unique case (reg_addr)
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_STAT: reg_rdata = {busy, stat_rdy, 2'b00, stat_unr, stat_ovf,
                             rx_empty, rx_full, tx_empty, tx_full, 22'd0};
      OFS_RXQ:  reg_rdata = rx_empty ? '0 : rx_head;
      default:  reg_rdata = '0;
    endcase
  end

  // R6: completion raises the ready flag while busy drops
  a_r6_done_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (stat_rdy && !busy));
  // R7: push into a full transmit queue flags overflow
  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && tx_full) |=> stat_ovf);
  // R8: pop from an empty receive queue flags underrun
  a_r8_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && rx_empty) |=> stat_unr);
endmodule

// File: tb/sfm_master_bench.sv
module sfm_master_bench;
  localparam int DIV = 4;
  localparam time CLK = 4ns;
  localparam logic [5:0] A_CMD = 6'h00, A_STAT = 6'h04, A_TX = 6'h10, A_RX = 6'h20;
  localparam logic [31:0] CSON = 32'h0000_3000, EN = 32'h0000_C000, GO = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, cs_n, mosi, miso = 1'b0;
  int total = 0, bad = 0;

  // device model state
  logic s_pol = 1'b0, s_edge = 1'b0;
  logic [31:0] s_tx = '0, s_rx = '0;
  int s_idx = 0, s_cnt = 0, s_lead = 0, sck_bad = 0;
  time s_last = 0;

  always #(CLK/2) clk = ~clk;

  sfm_master #(.DIV(DIV), .FIFO_DEPTH(4)) u_sfm_master (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  initial forever begin
    @(sck);
    if (sck != s_pol) begin
      if (s_lead > 0 && ($time - s_last) != DIV * CLK) sck_bad++;
      s_last = $time;
      s_lead++;
    end
    if ((sck != s_pol) != s_edge) begin
      s_rx = {s_rx[30:0], mosi};
      s_cnt++;
    end else if (s_idx >= 0) begin
      miso = s_tx[s_idx];
      s_idx--;
    end
  end

  function automatic logic [31:0] lowmask(input int n);
    return 32'((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int guard = 0;
    do begin rd(A_STAT, s); guard++; end while (s[31] && guard < 1000);
  endtask

  task automatic dev_load(input int n, input logic [31:0] w);
    s_tx = w; s_rx = '0; s_cnt = 0; s_lead = 0; sck_bad = 0;
    if (!s_edge) begin miso = w[n-1]; s_idx = n - 2; end
    else s_idx = n - 1;
  endtask

  task automatic run(input int m, input int n, input logic [31:0] sw, input logic [31:0] en);
    logic [31:0] c;
    c = CSON | en | (32'(m >> 1) << 26) | (32'(m & 1) << 18) | 32'(n - 1);
    s_pol = m[1]; s_edge = m[0];
    wr(A_CMD, c);
    dev_load(n, sw);
    wr(A_CMD, c | GO);
    wait_idle();
  endtask

  initial begin
    logic [31:0] v, st, txd, sw;
    logic [31:0] wq [4];
    logic [31:0] rq [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(A_STAT, v);
    chk("R10 reset status", v, 32'h0280_0000);
    chk("R5 reset cs_n", {31'd0, cs_n}, 32'd1);
    chk("R3 reset sck", {31'd0, sck}, 32'd0);

    // R1: command readback masks fields and hides start
    wr(A_CMD, 32'hBFFF_FFFF);
    rd(A_CMD, v);
    chk("R1 cmd readback", v, 32'h0C0C_F01F);
    rd(A_TX, v);
    chk("R1 tx port reads zero", v, 32'd0);

    // R5: software select, inverted
    wr(A_CMD, 32'h0000_3000);
    chk("R5 soft select low", {31'd0, cs_n}, 32'd0);
    wr(A_CMD, 32'h0000_1000);
    chk("R5 soft select high", {31'd0, cs_n}, 32'd1);
    // R5: automatic select follows busy
    s_pol = 1'b0; s_edge = 1'b0;
    wr(A_CMD, EN | 32'd7);
    wr(A_TX, 32'h5A);
    dev_load(8, 32'h3C);
    wr(A_CMD, EN | GO | 32'd7);
    chk("R5 auto select during transfer", {31'd0, cs_n}, 32'd0);
    wait_idle();
    chk("R5 auto select after transfer", {31'd0, cs_n}, 32'd1);
    rd(A_RX, v);
    chk("R4 auto-select receive", v, 32'h3C);

    // full sweep: every mode, every length
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 32; n++) begin
        txd = 32'hA5C3_0F96 ^ (32'(n) * 32'h0101_0101) ^ 32'(m * 7);
        sw  = 32'h6B1D_E247 ^ (32'(n) * 32'h0203_0405) ^ 32'(m << 9);
        wr(A_TX, txd);
        run(m, n, sw, EN);
        chk($sformatf("R4 device got m%0d n%0d", m, n), s_rx, txd & lowmask(n));
        chk($sformatf("R2 bit count m%0d n%0d", m, n), 32'(s_cnt), 32'(n));
        rd(A_RX, v);
        chk($sformatf("R4 rx word m%0d n%0d", m, n), v, sw & lowmask(n));
        chk($sformatf("R3 sck period/idle m%0d n%0d", m, n),
            {30'd0, sck_bad != 0, sck}, {31'd0, m[1]});
        rd(A_STAT, st);
        chk($sformatf("R6 rdy set m%0d n%0d", m, n), {31'd0, st[30]}, 32'd1);
        wr(A_STAT, st);
      end
    end

    // R2: start during a busy transfer is ignored
    wr(A_TX, 32'h0000_BEEF);
    run_no_wait();
    wr(A_CMD, CSON | EN | GO | 32'd7);
    wait_idle();
    chk("R2 second start ignored (bits)", 32'(s_cnt), 32'd16);
    rd(A_RX, v);
    chk("R2 single receive word", v, 32'h0000_1234);
    rd(A_STAT, v);
    chk("R2 receive queue empty", {31'd0, v[25]}, 32'd1);

    // R12: transmit and receive disabled
    wr(A_STAT, 32'h3000_0000);
    wr(A_TX, 32'h0000_00FF);
    run(0, 8, 32'hAA, 32'd0);
    chk("R12 zeros shifted", s_rx, 32'd0);
    rd(A_STAT, v);
    chk("R12 tx kept, rx untouched", {30'd0, v[23], v[25]}, 32'd1);
    // R11: transmit flush
    wr(A_STAT, 32'h1000_0000);
    rd(A_STAT, v);
    chk("R11 tx flushed", {31'd0, v[23]}, 32'd1);

    // R10 / R7: fill, overflow, ordering
    for (int k = 0; k < 4; k++) begin
      wq[k] = 32'h1111_0000 * 32'(k + 1) + 32'(k);
      rq[k] = 32'hC0DE_0000 + 32'(k * 3);
      wr(A_TX, wq[k]);
    end
    rd(A_STAT, v);
    chk("R10 tx full flags", {30'd0, v[22], v[23]}, 32'd2);
    wr(A_TX, 32'hDEAD_DEAD);
    rd(A_STAT, v);
    chk("R7 overflow flag", {31'd0, v[26]}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      run(0, 32, rq[k], EN);
      chk($sformatf("R10 tx order %0d", k), s_rx, wq[k]);
    end
    rd(A_STAT, v);
    chk("R10 rx full, tx empty (R7 drop)", {30'd0, v[24], v[23]}, 32'd3);
    // R11: receive flush keeps the words until asked
    for (int k = 0; k < 4; k++) begin
      rd(A_RX, v);
      chk($sformatf("R10 rx order %0d", k), v, rq[k]);
    end
    // R8: underrun
    rd(A_RX, v);
    chk("R8 empty read returns zero", v, 32'd0);
    rd(A_STAT, st);
    chk("R8 underrun flag", {31'd0, st[27]}, 32'd1);
    // R9: write-back clears events, other bits do not
    wr(A_STAT, 32'h03C0_0000);
    rd(A_STAT, v);
    chk("R9 non-event write keeps flags", v & 32'h4C00_0000, st & 32'h4C00_0000);
    wr(A_STAT, st);
    rd(A_STAT, v);
    chk("R9 events cleared", v & 32'h4C00_0000, 32'd0);
    // R11: receive flush
    run(0, 8, 32'h77, EN);
    wr(A_STAT, 32'h2000_0000);
    rd(A_STAT, v);
    chk("R11 rx flushed", {31'd0, v[25]}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run_no_wait();
    s_pol = 1'b0; s_edge = 1'b0;
    wr(A_CMD, CSON | EN | 32'd15);
    dev_load(16, 32'h0000_1234);
    wr(A_CMD, CSON | EN | GO | 32'd15);
  endtask

  initial begin
    #(CLK * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule